// File: doc/BRIEF.md
# I2C Dual FIFO Threshold Buffer

This block sits between the byte engine of an I2C controller and software. It holds one byte FIFO for outgoing data and one for incoming data. Software fills the transmit FIFO and empties the receive FIFO through an 8-bit data port. The engine takes transmit bytes and delivers receive bytes through a push/pop interface. A configuration word sets a threshold for each direction, flushes either FIFO, and enables DMA requests. A status word reports both fill levels and the FIFO depth.

At the start of each transfer a byte count is loaded. The block uses it in three places:
- Software-side counters track how many bytes software still has to write or read. They decide when the tail of a transfer raises a drain event instead of a ready event.
- An engine-side counter tracks how many bytes still have to cross the bus. It qualifies the transmit underflow event.
- Overrun and underflow are reported as single-cycle pulses.

Top module: `i2c_dual_fifo_buf`

## Requirements
- R1: A configuration write stores the transmit threshold-minus-one in bits 5:0, the transmit DMA enable in bit 7, the receive threshold-minus-one in bits 13:8 and the receive DMA enable in bit 15. The readback returns those fields in the same positions, and bits 6 and 14 always read zero. All fields are zero after reset.
- R2: A configuration write with bit 6 set empties the transmit FIFO, and one with bit 14 set empties the receive FIFO. The flush takes effect at that clock edge and overrides any push or pop in the same cycle.
- R3: Each data write pushes one byte into the transmit FIFO. Each data read pops one byte from the receive FIFO. The read data shows the oldest byte, and both FIFOs keep first-in first-out order.
- R4: A read of an empty receive FIFO returns zero and changes nothing. A write to a full transmit FIFO is dropped and does not decrement the software transmit count.
- R5: The status word carries the transmit level in bits 5:0, the receive level in bits 13:8 and a depth code in bits 15:14, where the depth is 8 shifted left by the code.
- R6: Receive ready is high while the receive level is at least the receive threshold.
- R7: Transmit ready is high while the free transmit space is at least the transmit threshold and the bytes software still has to write are at least the threshold.
- R8: Receive drain is high while the remaining receive count is nonzero and below the threshold, and the receive level equals that count.
- R9: Transmit drain is high while the remaining transmit count is nonzero and below the threshold, and the free space can hold all of it.
- R10: An engine push into a full receive FIFO drops the byte and raises the overrun pulse for one cycle.
- R11: An engine pop from an empty transmit FIFO while the bus byte count is nonzero raises the underflow pulse for one cycle.
- R12: Each DMA request is high exactly while its ready event is high and its enable bit is set.
- R13: A transfer start loads the given length into the software transmit, software receive and bus counters. Accepted data writes, data reads and engine transfers each decrement their counter, which saturates at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| buf_stat | output | 16 | Fill levels and depth code |
| dat_wr | input | 1 | Software data write (transmit push) |
| dat_wdata | input | DW | Software write byte |
| dat_rd | input | 1 | Software data read (receive pop) |
| dat_rdata | output | DW | Oldest receive byte, zero when empty |
| xfer_start | input | 1 | Load transfer length into counters |
| xfer_len | input | CNTW | Transfer length in bytes |
| eng_tx_pop | input | 1 | Engine takes a transmit byte |
| eng_tx_data | output | DW | Oldest transmit byte, zero when empty |
| eng_tx_avail | output | 1 | Transmit FIFO holds a byte |
| eng_rx_push | input | 1 | Engine delivers a receive byte |
| eng_rx_data | input | DW | Received byte |
| tx_rdy | output | 1 | Transmit threshold event |
| tx_drn | output | 1 | Transmit drain event |
| rx_rdy | output | 1 | Receive threshold event |
| rx_drn | output | 1 | Receive drain event |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_ovr | output | 1 | Receive overrun pulse |
| tx_udf | output | 1 | Transmit underflow pulse |

## Verification
All state is registered, and every level-type output is derived from that state. A strobe applied before a clock edge therefore shows up in levels, status, read data, events and DMA requests one nanosecond after that edge, and the overrun and underflow pulses appear at the same point for exactly one cycle. The bench steps one clock at a time. It updates a queue-based model from the inputs that were present at the edge, then compares every output one nanosecond later, so every result is checked in the first cycle it is due. The stimulus covers threshold crossings, tail-of-transfer drains, full and empty accesses, flushes and counter exhaustion.

// File: rtl/i2cbuf_pkg.sv
// Shared field positions and types for the dual FIFO threshold buffer.
// Assumes threshold fields of six bits and a 16-bit configuration word.
package i2cbuf_pkg;
    localparam int THR_W        = 6;
    localparam int CFG_TX_THR   = 0;
    localparam int CFG_TX_FLUSH = 6;
    localparam int CFG_TX_DMA   = 7;
    localparam int CFG_RX_THR   = 8;
    localparam int CFG_RX_FLUSH = 14;
    localparam int CFG_RX_DMA   = 15;

    typedef struct packed {
        logic             dma_en;
        logic [THR_W-1:0] thr_m1;
    } chan_cfg_t;
endpackage

// File: rtl/ibuf_fifo.sv
// Synchronous byte FIFO with a fill level output.
// A push is dropped when the FIFO is full, and a pop of an empty FIFO does nothing.
// A flush empties the FIFO and overrides push and pop. The read data is zero when empty.
// Assumes DEPTH is a power of two.
module ibuf_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LVLW = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [DW-1:0]   wdata,
    input  logic            pop,
    output logic [DW-1:0]   rdata,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LVLW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem[rp];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and level bookkeeping, with flush clearing both pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + LVLW'(do_push) - LVLW'(do_pop);
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVLW'(DEPTH));
    // R4
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
    // R2
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/ibuf_count.sv
// Down-counter loaded at transfer start and decremented by accepted byte moves.
// The load has priority over the decrement, and the counter saturates at zero.
module ibuf_count #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CNTW-1:0] load_val,
    input  logic            dec,
    output logic [CNTW-1:0] cnt
);
    // Load, then decrement with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // R13
    sat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/ibuf_events.sv
// Threshold and drain evaluation for one direction.
// IS_RX selects the receive variant, which works from the fill level.
// The transmit variant works from the free space.
// Assumes CNTW is wider than both the level and the threshold.
module ibuf_events #(
    parameter int DEPTH = 16,
    parameter int CNTW  = 16,
    parameter bit IS_RX = 1'b0,
    localparam int LVLW = $clog2(DEPTH) + 1,
    localparam int TW   = i2cbuf_pkg::THR_W
) (
    input  logic [TW-1:0]   thr_m1,
    input  logic [LVLW-1:0] level,
    input  logic [CNTW-1:0] left,
    output logic            rdy,
    output logic            drn
);
    logic [CNTW-1:0] thr;
    logic [CNTW-1:0] lvl_w;

    assign thr   = CNTW'(thr_m1) + 1'b1;
    assign lvl_w = CNTW'(level);

    generate
        if (IS_RX) begin : g_rx
            // Receive: ready on level, drain when every remaining byte is present.
            always_comb begin
                rdy = (lvl_w >= thr);
                drn = (left != '0) && (left < thr) && (lvl_w == left);
            end
        end else begin : g_tx
            logic [CNTW-1:0] free_w;
            assign free_w = CNTW'(DEPTH) - lvl_w;
            // Transmit: ready on free space, drain when the tail fits.
            always_comb begin
                rdy = (free_w >= thr) && (left >= thr);
                drn = (left != '0) && (left < thr) && (free_w >= left);
            end
        end
    endgenerate
endmodule

// File: rtl/i2c_dual_fifo_buf.sv
// Transmit and receive byte FIFOs of an I2C controller, with threshold and drain events.
// Software talks to the block through configuration, status and data words.
// The bus engine talks to it through byte push/pop strobes.
// All state is registered, the event outputs come from that state, and the
// overrun and underflow pulses are registered.
// Assumes DEPTH_CODE is at most 2, so that each level fits its 6-bit status field.
module i2c_dual_fifo_buf #(
    parameter int DEPTH_CODE = 1,
    parameter int DW         = 8,
    parameter int CNTW       = 16,
    localparam int DEPTH     = 8 << DEPTH_CODE,
    localparam int LVLW      = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [15:0]     cfg_wdata,
    output logic [15:0]     cfg_rdata,
    output logic [15:0]     buf_stat,
    input  logic            dat_wr,
    input  logic [DW-1:0]   dat_wdata,
    input  logic            dat_rd,
    output logic [DW-1:0]   dat_rdata,
    input  logic            xfer_start,
    input  logic [CNTW-1:0] xfer_len,
    input  logic            eng_tx_pop,
    output logic [DW-1:0]   eng_tx_data,
    output logic            eng_tx_avail,
    input  logic            eng_rx_push,
    input  logic [DW-1:0]   eng_rx_data,
    output logic            tx_rdy,
    output logic            tx_drn,
    output logic            rx_rdy,
    output logic            rx_drn,
    output logic            tx_dma_req,
    output logic            rx_dma_req,
    output logic            rx_ovr,
    output logic            tx_udf
);
    import i2cbuf_pkg::*;

    chan_cfg_t       tx_cfg, rx_cfg;
    logic            tx_flush, rx_flush;
    logic [LVLW-1:0] tx_lvl, rx_lvl;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic [CNTW-1:0] sw_tx_left, sw_rx_left, bus_left;
    logic            tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

    assign tx_flush = cfg_wr && cfg_wdata[CFG_TX_FLUSH];
    assign rx_flush = cfg_wr && cfg_wdata[CFG_RX_FLUSH];

    // Configuration fields; the flush bits are strobes and are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cfg <= '0;
            rx_cfg <= '0;
        end else if (cfg_wr) begin
            tx_cfg.thr_m1 <= cfg_wdata[CFG_TX_THR +: THR_W];
            tx_cfg.dma_en <= cfg_wdata[CFG_TX_DMA];
            rx_cfg.thr_m1 <= cfg_wdata[CFG_RX_THR +: THR_W];
            rx_cfg.dma_en <= cfg_wdata[CFG_RX_DMA];
        end
    end

    assign cfg_rdata = {rx_cfg.dma_en, 1'b0, rx_cfg.thr_m1,
                        tx_cfg.dma_en, 1'b0, tx_cfg.thr_m1};
    assign buf_stat  = {2'(DEPTH_CODE), 6'(rx_lvl), 2'b00, 6'(tx_lvl)};

    assign tx_push_ok = dat_wr && !tx_full && !tx_flush;
    assign tx_pop_ok  = eng_tx_pop && !tx_empty && !tx_flush;
    assign rx_push_ok = eng_rx_push && !rx_full && !rx_flush;
    assign rx_pop_ok  = dat_rd && !rx_empty && !rx_flush;

    ibuf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(dat_wr), .wdata(dat_wdata), .pop(eng_tx_pop),
        .rdata(eng_tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    ibuf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .wdata(eng_rx_data), .pop(dat_rd),
        .rdata(dat_rdata), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    assign eng_tx_avail = !tx_empty;

    ibuf_count #(.CNTW(CNTW)) u_sw_tx_cnt (
        .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(xfer_len),
        .dec(tx_push_ok), .cnt(sw_tx_left)
    );
    ibuf_count #(.CNTW(CNTW)) u_sw_rx_cnt (
        .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(xfer_len),
        .dec(rx_pop_ok), .cnt(sw_rx_left)
    );
    ibuf_count #(.CNTW(CNTW)) u_bus_cnt (
        .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(xfer_len),
        .dec(tx_pop_ok || rx_push_ok), .cnt(bus_left)
    );

    ibuf_events #(.DEPTH(DEPTH), .CNTW(CNTW), .IS_RX(1'b0)) u_tx_ev (
        .thr_m1(tx_cfg.thr_m1), .level(tx_lvl), .left(sw_tx_left),
        .rdy(tx_rdy), .drn(tx_drn)
    );
    ibuf_events #(.DEPTH(DEPTH), .CNTW(CNTW), .IS_RX(1'b1)) u_rx_ev (
        .thr_m1(rx_cfg.thr_m1), .level(rx_lvl), .left(sw_rx_left),
        .rdy(rx_rdy), .drn(rx_drn)
    );

    assign tx_dma_req = tx_cfg.dma_en && tx_rdy;
    assign rx_dma_req = rx_cfg.dma_en && rx_rdy;

    // Error pulses, judged on the fill state before the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ovr <= 1'b0;
            tx_udf <= 1'b0;
        end else begin
            rx_ovr <= eng_rx_push && rx_full && !rx_flush;
            tx_udf <= eng_tx_pop && tx_empty && (bus_left != '0);
        end
    end

    // R10
    rx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !rx_flush && !dat_rd) |=> (rx_ovr && rx_full));
    // R11
    tx_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_pop && tx_empty && bus_left != '0 && !xfer_start) |=> tx_udf);
    // R13
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (sw_tx_left == $past(xfer_len) && bus_left == $past(xfer_len)));
    // R8
    rx_drn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drn |-> !rx_rdy);
    // R9
    tx_drn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drn |-> !tx_rdy);
endmodule

// File: tb/tb_i2c_dual_fifo_buf.sv
module tb_i2c_dual_fifo_buf;
    localparam int DC    = 1;
    localparam int DEPTH = 8 << DC;

    logic        clk = 0, rst_n = 0;
    logic        cfg_wr = 0, dat_wr = 0, dat_rd = 0, xfer_start = 0;
    logic        eng_tx_pop = 0, eng_rx_push = 0;
    logic [15:0] cfg_wdata = 0, xfer_len = 0;
    logic [7:0]  dat_wdata = 0, eng_rx_data = 0;
    logic [15:0] cfg_rdata, buf_stat;
    logic [7:0]  dat_rdata, eng_tx_data;
    logic        eng_tx_avail, tx_rdy, tx_drn, rx_rdy, rx_drn;
    logic        tx_dma_req, rx_dma_req, rx_ovr, tx_udf;

    int checks = 0, errors = 0, cycles = 0;

    // Reference model state.
    byte unsigned txq[$], rxq[$];
    int tx_left, rx_left, bus_left, txthr_m1, rxthr_m1;
    bit txdma, rxdma, e_ovr, e_udf;

    i2c_dual_fifo_buf dut (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit txf, rxf, tpo, tpu, rpo, rpu;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            tx_left = 0; rx_left = 0; bus_left = 0;
            txthr_m1 = 0; rxthr_m1 = 0; txdma = 0; rxdma = 0;
            e_ovr = 0; e_udf = 0;
            return;
        end
        txf = cfg_wr && cfg_wdata[6];
        rxf = cfg_wr && cfg_wdata[14];
        e_ovr = eng_rx_push && rxq.size() == DEPTH && !rxf;
        e_udf = eng_tx_pop && txq.size() == 0 && bus_left != 0;
        tpo = eng_tx_pop && txq.size() > 0 && !txf;
        tpu = dat_wr && txq.size() < DEPTH && !txf;
        rpo = dat_rd && rxq.size() > 0 && !rxf;
        rpu = eng_rx_push && rxq.size() < DEPTH && !rxf;
        if (txf) txq.delete();
        else begin
            if (tpo) void'(txq.pop_front());
            if (tpu) txq.push_back(dat_wdata);
        end
        if (rxf) rxq.delete();
        else begin
            if (rpo) void'(rxq.pop_front());
            if (rpu) rxq.push_back(eng_rx_data);
        end
        if (xfer_start) begin
            tx_left = xfer_len; rx_left = xfer_len; bus_left = xfer_len;
        end else begin
            if (tpu && tx_left > 0) tx_left--;
            if (rpo && rx_left > 0) rx_left--;
            if ((tpo || rpu) && bus_left > 0) bus_left--;
        end
        if (cfg_wr) begin
            txthr_m1 = cfg_wdata[5:0]; txdma = cfg_wdata[7];
            rxthr_m1 = cfg_wdata[13:8]; rxdma = cfg_wdata[15];
        end
    endtask

    task automatic compare();
        int tt, rt, fr;
        bit erdy_t, erdy_r;
        tt = txthr_m1 + 1; rt = rxthr_m1 + 1; fr = DEPTH - txq.size();
        erdy_t = fr >= tt && tx_left >= tt;
        erdy_r = rxq.size() >= rt;
        chk("R1 cfg readback", cfg_rdata,
            (int'(rxdma) << 15) | (rxthr_m1 << 8) | (int'(txdma) << 7) | txthr_m1);
        chk("R5 status", buf_stat, (DC << 14) | (rxq.size() << 8) | txq.size());
        chk("R3/R4 rx read data", dat_rdata, rxq.size() > 0 ? rxq[0] : 0);
        chk("R3 tx head", eng_tx_data, txq.size() > 0 ? txq[0] : 0);
        chk("R3 tx avail", eng_tx_avail, txq.size() > 0);
        chk("R7 tx ready", tx_rdy, erdy_t);
        chk("R9 tx drain", tx_drn, tx_left != 0 && tx_left < tt && fr >= tx_left);
        chk("R6 rx ready", rx_rdy, erdy_r);
        chk("R8 rx drain", rx_drn, rx_left != 0 && rx_left < rt && rxq.size() == rx_left);
        chk("R12 tx dma", tx_dma_req, txdma && erdy_t);
        chk("R12 rx dma", rx_dma_req, rxdma && erdy_r);
        chk("R10 overrun", rx_ovr, e_ovr);
        chk("R11 underflow", tx_udf, e_udf);
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        #1;
        compare();
        cfg_wr = 0; dat_wr = 0; dat_rd = 0; xfer_start = 0;
        eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic wr_cfg(int v);  cfg_wr = 1; cfg_wdata = 16'(v); tick(); endtask
    task automatic start(int n);   xfer_start = 1; xfer_len = 16'(n); tick(); endtask
    task automatic sw_wr(int b);   dat_wr = 1; dat_wdata = 8'(b); tick(); endtask
    task automatic sw_rd();        dat_rd = 1; tick(); endtask
    task automatic e_pop();        eng_tx_pop = 1; tick(); endtask
    task automatic e_push(int b);  eng_rx_push = 1; eng_rx_data = 8'(b); tick(); endtask

    initial begin
        repeat (3) tick();              // reset state compared each tick (R1, R5)
        rst_n = 1;
        tick();
        // R1: thresholds 4/4, DMA on, flush bits read back as zero
        wr_cfg(16'hC3C3);
        // R13, R7, R9: transmit tail turns into drain
        start(10);
        for (int i = 0; i < 10; i++) sw_wr(8'h10 + i);
        // R3: engine drains in order; R11: no underflow once the count is exhausted
        for (int i = 0; i < 11; i++) e_pop();
        start(3);
        e_pop();                        // R11 underflow pulse
        tick();
        // R4: full transmit FIFO drops extra writes
        start(20);
        for (int i = 0; i < 18; i++) sw_wr(8'hA0 + i);
        e_pop(); sw_wr(8'h55);          // room again, accepted
        // R2: transmit flush
        wr_cfg(16'h0343);
        // R6, R8: receive threshold then drain
        start(6);
        for (int i = 0; i < 4; i++) e_push(8'h30 + i);
        for (int i = 0; i < 4; i++) sw_rd();
        for (int i = 0; i < 2; i++) e_push(8'h40 + i);
        sw_rd(); sw_rd();
        sw_rd();                        // R4: empty read returns zero
        // R10: overrun on a full receive FIFO
        wr_cfg(16'h8303);
        start(40);
        for (int i = 0; i < DEPTH + 2; i++) e_push(i);
        sw_rd();
        wr_cfg(16'h4000);               // R2: receive flush, R12: DMA off
        // R3: simultaneous push and pop on both FIFOs
        start(8);
        sw_wr(1); dat_wr = 1; dat_wdata = 2; eng_tx_pop = 1; tick();
        e_push(5); dat_rd = 1; eng_rx_push = 1; eng_rx_data = 6; tick();
        repeat (2) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule